// File: doc/BRIEF.md
# SDRAM Self-Refresh Retention Sequencer

This block keeps SDRAM contents alive while the core supply of a memory controller is switched off. When a backup request arrives, it asks the controller to put the memory into self-refresh and waits for the acknowledge. It then lets a programmable dwell pass and drives an active-low clamp that forces the pad clock-enable low. Next it raises a retention flag and releases core power. The sequencer state, the clamp and the retention flag sit in an always-on domain. The core reset input does not touch them.

On wake the block turns core power back on and requests a core reset until power is good. It lifts the clamp only after it has seen the core reset asserted and then released. Software reads the retention flag after reset. The flag tells it whether to resume from retained self-refresh or to run a full memory initialization. Software must clear the flag before the internal clock-enable can be driven high again. An attempt to raise it earlier is refused and sets a sticky error bit.

All pins are plain level or single-cycle pulse signals. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure.

Top module: `sr_retention_seq`

## Requirements
- R1: While `hold_n` is low, `cke_pad` is low whatever the internal clock-enable holds. While `hold_n` is high, `cke_pad` follows the internal clock-enable. A `sw_cke_set` pulse sets the internal clock-enable one cycle later and a `sw_cke_clr` pulse clears it one cycle later.
- R2: A `bkp_req` pulse in the idle state raises `sr_req` on the next cycle. `sr_req` stays high until `sr_ack` is sampled. `hold_n` falls exactly `DWELL_CYC` cycles after the edge that samples `sr_ack`.
- R3: One cycle after `hold_n` falls, `ret_flag` goes high and `core_pwr_en` goes low. `core_pwr_en` stays low until `wake_req` is sampled.
- R4: A low `core_rst_n` clears the internal clock-enable and `cke_err` at once. It leaves `ret_flag`, `hold_n` and the sequencer state unchanged.
- R5: After `wake_req`, `core_pwr_en` is high and `rst_req` is high until `pwr_good` is sampled. `hold_n` stays low until `core_rst_n` has been sampled low and afterwards sampled high. It rises on the edge that samples that high level.
- R6: In the idle state `hold_n` is high.
- R7: `sw_ret_clr` clears `ret_flag` and returns the sequencer to idle only once the clamp has been released. Before that it has no effect.
- R8: A `sw_cke_set` pulse while the sequencer is not idle is refused. This covers the whole time `ret_flag` is set. The internal clock-enable stays low and `cke_err` goes high and stays high until a core reset.
- R9: The edge that samples `sr_ack` during the self-refresh request also clears the internal clock-enable.
- R10: A low `aon_rst_n` puts the sequencer in idle at once, with `hold_n` high, `ret_flag` low, `sr_req` and `rst_req` low and `core_pwr_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| aon_rst_n | input | 1 | Always-on domain reset, active low, asynchronous |
| core_rst_n | input | 1 | Core power-on reset, active low, asynchronous |
| bkp_req | input | 1 | Backup request pulse |
| sr_ack | input | 1 | Controller reports memory in self-refresh |
| pwr_good | input | 1 | Core supply is up |
| wake_req | input | 1 | Wake-up request pulse |
| sw_cke_set | input | 1 | Software write: drive clock-enable high |
| sw_cke_clr | input | 1 | Software write: drive clock-enable low |
| sw_ret_clr | input | 1 | Software write: clear retention flag |
| sr_req | output | 1 | Request to controller to enter self-refresh |
| core_pwr_en | output | 1 | Core supply enable |
| rst_req | output | 1 | Request for core power-on reset |
| hold_n | output | 1 | Active-low clamp on the pad clock-enable |
| cke_pad | output | 1 | Clock-enable driven to the memory pad |
| ret_flag | output | 1 | Memory is held in retained self-refresh |
| cke_err | output | 1 | Sticky: a refused clock-enable write occurred |

## Verification
The hardest case to reach is a core reset that arrives while the always-on clamp is in force. The clock-enable must stay low through it, and the clamp must not lift until reset has been seen asserted and then released. The stimulus drives a full backup with a controller that is slow to acknowledge. It pulses core reset during power-off and holds it through the wake. A second backup wakes with core reset never asserted, to show the clamp stays down. Refused clock-enable writes are issued during power-off and again after release but before the flag is cleared. A behavioural model in the bench is compared against every output on every clock.

// File: rtl/sr_ret_pkg.sv
package sr_ret_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE      = 3'd0,
    SQ_SR_REQ    = 3'd1,
    SQ_DWELL     = 3'd2,
    SQ_CLAMP     = 3'd3,
    SQ_PWR_OFF   = 3'd4,
    SQ_IN_RESET  = 3'd5,
    SQ_UNCLAMP   = 3'd6,
    SQ_AWAIT_CLR = 3'd7
  } seq_state_e;
endpackage

// File: rtl/sr_ret_seq.sv
// Always-on sequencer: state, dwell counter, clamp and retention flag.
module sr_ret_seq
  import sr_ret_pkg::*;
#(
  parameter int DWELL_CYC = 4
) (
  input  logic       clk,
  input  logic       aon_rst_n,
  input  logic       core_rst_n,
  input  logic       bkp_req,
  input  logic       sr_ack,
  input  logic       pwr_good,
  input  logic       wake_req,
  input  logic       sw_ret_clr,
  output seq_state_e state_o,
  output logic       hold_n_o,
  output logic       ret_flag_o
);
  localparam int CW = (DWELL_CYC > 1) ? $clog2(DWELL_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DWELL_CYC - 1);

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          hold_q;
  logic          ret_q;
  logic          rst_seen_q;

  always_ff @(posedge clk or negedge aon_rst_n) begin
    if (!aon_rst_n) begin
      state_q    <= SQ_IDLE;
      cnt_q      <= '0;
      hold_q     <= 1'b1;
      ret_q      <= 1'b0;
      rst_seen_q <= 1'b0;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (bkp_req) state_q <= SQ_SR_REQ;
        SQ_SR_REQ: if (sr_ack) begin
          cnt_q   <= '0;
          state_q <= SQ_DWELL;
        end
        SQ_DWELL: begin
          if (cnt_q == CNT_LAST) begin
            hold_q  <= 1'b0;
            state_q <= SQ_CLAMP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SQ_CLAMP: begin
          ret_q   <= 1'b1;
          state_q <= SQ_PWR_OFF;
        end
        SQ_PWR_OFF: if (wake_req) begin
          rst_seen_q <= 1'b0;
          state_q    <= SQ_IN_RESET;
        end
        SQ_IN_RESET: begin
          if (!core_rst_n) rst_seen_q <= 1'b1;
          if (pwr_good) state_q <= SQ_UNCLAMP;
        end
        SQ_UNCLAMP: begin
          if (!core_rst_n) begin
            rst_seen_q <= 1'b1;
          end else if (rst_seen_q) begin
            hold_q  <= 1'b1;
            state_q <= SQ_AWAIT_CLR;
          end
        end
        SQ_AWAIT_CLR: if (sw_ret_clr) begin
          ret_q   <= 1'b0;
          state_q <= SQ_IDLE;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign state_o    = state_q;
  assign hold_n_o   = hold_q;
  assign ret_flag_o = ret_q;

  AST_IDLE_UNCLAMPED: assert property (@(posedge clk) disable iff (!aon_rst_n)
    (state_q == SQ_IDLE) |-> hold_q); // R6
  AST_RELEASE_AFTER_RST: assert property (@(posedge clk) disable iff (!aon_rst_n)
    $rose(hold_q) |-> $past(core_rst_n)); // R5
  AST_SR_REQ_KEEP: assert property (@(posedge clk) disable iff (!aon_rst_n)
    (state_q == SQ_SR_REQ && !sr_ack) |=> (state_q == SQ_SR_REQ)); // R2
endmodule

// File: rtl/sr_ret_cke.sv
// Core-domain internal clock-enable register with refusal logic.
module sr_ret_cke (
  input  logic clk,
  input  logic core_rst_n,
  input  logic lock,
  input  logic sr_enter,
  input  logic sw_cke_set,
  input  logic sw_cke_clr,
  output logic cke_int_o,
  output logic cke_err_o
);
  logic cke_q;
  logic err_q;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      cke_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (sw_cke_set && lock) err_q <= 1'b1;
      if (sr_enter)                  cke_q <= 1'b0;
      else if (sw_cke_set && !lock)  cke_q <= 1'b1;
      else if (sw_cke_clr)           cke_q <= 1'b0;
    end
  end

  assign cke_int_o = cke_q;
  assign cke_err_o = err_q;

  AST_LOCKED_SET_FLAGS: assert property (@(posedge clk) disable iff (!core_rst_n)
    (sw_cke_set && lock) |=> cke_err_o); // R8
endmodule

// File: rtl/sr_retention_seq.sv
module sr_retention_seq
  import sr_ret_pkg::*;
#(
  parameter int DWELL_CYC = 4
) (
  input  logic clk,
  input  logic aon_rst_n,
  input  logic core_rst_n,
  input  logic bkp_req,
  input  logic sr_ack,
  input  logic pwr_good,
  input  logic wake_req,
  input  logic sw_cke_set,
  input  logic sw_cke_clr,
  input  logic sw_ret_clr,
  output logic sr_req,
  output logic core_pwr_en,
  output logic rst_req,
  output logic hold_n,
  output logic cke_pad,
  output logic ret_flag,
  output logic cke_err
);
  seq_state_e state;
  logic       cke_int;

  sr_ret_seq #(.DWELL_CYC(DWELL_CYC)) u_seq (
    .clk        (clk),
    .aon_rst_n  (aon_rst_n),
    .core_rst_n (core_rst_n),
    .bkp_req    (bkp_req),
    .sr_ack     (sr_ack),
    .pwr_good   (pwr_good),
    .wake_req   (wake_req),
    .sw_ret_clr (sw_ret_clr),
    .state_o    (state),
    .hold_n_o   (hold_n),
    .ret_flag_o (ret_flag)
  );

  sr_ret_cke u_cke (
    .clk        (clk),
    .core_rst_n (core_rst_n),
    .lock       (state != SQ_IDLE),
    .sr_enter   ((state == SQ_SR_REQ) && sr_ack),
    .sw_cke_set (sw_cke_set),
    .sw_cke_clr (sw_cke_clr),
    .cke_int_o  (cke_int),
    .cke_err_o  (cke_err)
  );

  assign sr_req      = (state == SQ_SR_REQ);
  assign core_pwr_en = (state != SQ_PWR_OFF);
  assign rst_req     = (state == SQ_IN_RESET);
  assign cke_pad     = cke_int & hold_n;

  AST_CLAMP_KEEPS_CKE_LOW: assert property (@(posedge clk) disable iff (!aon_rst_n)
    !hold_n |-> !cke_int); // R1
endmodule

// File: tb/sr_retention_seq_test.sv
module sr_retention_seq_test;
  localparam int D = 3;

  logic clk = 1'b0;
  logic aon_rst_n = 1'b0, core_rst_n = 1'b0;
  logic bkp_req = 0, sr_ack = 0, pwr_good = 1, wake_req = 0;
  logic sw_cke_set = 0, sw_cke_clr = 0, sw_ret_clr = 0;
  logic sr_req, core_pwr_en, rst_req, hold_n, cke_pad, ret_flag, cke_err;

  int errors = 0, checks = 0, cyc = 0;
  bit cmp_en = 0;

  always #5 clk = ~clk;

  sr_retention_seq #(.DWELL_CYC(D)) uut (
    .clk(clk), .aon_rst_n(aon_rst_n), .core_rst_n(core_rst_n),
    .bkp_req(bkp_req), .sr_ack(sr_ack), .pwr_good(pwr_good), .wake_req(wake_req),
    .sw_cke_set(sw_cke_set), .sw_cke_clr(sw_cke_clr), .sw_ret_clr(sw_ret_clr),
    .sr_req(sr_req), .core_pwr_en(core_pwr_en), .rst_req(rst_req),
    .hold_n(hold_n), .cke_pad(cke_pad), .ret_flag(ret_flag), .cke_err(cke_err)
  );

  // behavioural reference: 0 idle,1 req,2 dwell,3 clamp,4 off,5 reset,6 unclamp,7 await
  int m_st = 0, m_cnt = 0;
  bit m_hold = 1, m_ret = 0, m_seen = 0, m_cke = 0, m_err = 0;

  always @(posedge clk) begin
    cyc++;
    if (!aon_rst_n) begin
      m_st = 0; m_cnt = 0; m_hold = 1; m_ret = 0; m_seen = 0;
    end
    if (!core_rst_n) begin
      m_cke = 0; m_err = 0;
    end else begin
      if (sw_cke_set && m_st != 0) m_err = 1;
      if (m_st == 1 && sr_ack) m_cke = 0;
      else if (sw_cke_set && m_st == 0) m_cke = 1;
      else if (sw_cke_clr) m_cke = 0;
    end
    if (aon_rst_n) begin
      case (m_st)
        0: if (bkp_req) m_st = 1;
        1: if (sr_ack) begin m_cnt = 0; m_st = 2; end
        2: if (m_cnt == D - 1) begin m_hold = 0; m_st = 3; end else m_cnt++;
        3: begin m_ret = 1; m_st = 4; end
        4: if (wake_req) begin m_seen = 0; m_st = 5; end
        5: begin if (!core_rst_n) m_seen = 1; if (pwr_good) m_st = 6; end
        6: if (!core_rst_n) m_seen = 1;
           else if (m_seen) begin m_hold = 1; m_st = 7; end
        7: if (sw_ret_clr) begin m_ret = 0; m_st = 0; end
        default: m_st = 0;
      endcase
    end
  end

  task automatic chk(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (cmp_en) begin
    chk("R1", cke_pad, m_cke & m_hold, "cke_pad");
    chk("R2", sr_req, m_st == 1, "sr_req");
    chk("R3", core_pwr_en, m_st != 4, "core_pwr_en");
    chk("R5", rst_req, m_st == 5, "rst_req");
    chk("R5", hold_n, m_hold, "hold_n");
    chk("R7", ret_flag, m_ret, "ret_flag");
    chk("R8", cke_err, m_err, "cke_err");
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 20000) begin
    errors++; checks++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    tick(3);
    // R10: reset state
    chk("R10", hold_n, 1'b1, "hold_n in reset");
    chk("R10", ret_flag, 1'b0, "ret_flag in reset");
    chk("R10", core_pwr_en, 1'b1, "pwr_en in reset");
    chk("R10", sr_req, 1'b0, "sr_req in reset");
    aon_rst_n = 1; core_rst_n = 1; cmp_en = 1;
    tick();
    sw_cke_set = 1; tick(); sw_cke_set = 0;
    chk("R1", cke_pad, 1'b1, "cke set while idle");
    chk("R6", hold_n, 1'b1, "idle clamp off");
    sw_cke_clr = 1; tick(); sw_cke_clr = 0;
    chk("R1", cke_pad, 1'b0, "cke cleared");
    sw_cke_set = 1; tick(); sw_cke_set = 0;
    // first backup, slow acknowledge
    bkp_req = 1; tick(); bkp_req = 0;
    chk("R2", sr_req, 1'b1, "sr_req after bkp_req");
    tick(3);
    chk("R2", sr_req, 1'b1, "sr_req held without ack");
    chk("R9", cke_pad, 1'b1, "cke before ack");
    sr_ack = 1; tick(); sr_ack = 0;
    chk("R9", cke_pad, 1'b0, "ack clears cke");
    chk("R2", sr_req, 1'b0, "sr_req dropped after ack");
    tick(D - 1);
    chk("R2", hold_n, 1'b1, "clamp not before dwell");
    tick();
    chk("R2", hold_n, 1'b0, "clamp at dwell end");
    tick();
    chk("R3", ret_flag, 1'b1, "ret_flag set");
    chk("R3", core_pwr_en, 1'b0, "power off");
    pwr_good = 0;
    sw_cke_set = 1; tick(); sw_cke_set = 0;
    chk("R8", cke_err, 1'b1, "refused set during off");
    chk("R8", cke_pad, 1'b0, "pad low during off");
    core_rst_n = 0; tick();
    chk("R4", cke_err, 1'b0, "core reset clears err");
    chk("R4", ret_flag, 1'b1, "ret survives core reset");
    chk("R4", hold_n, 1'b0, "clamp survives core reset");
    tick(3);
    chk("R3", core_pwr_en, 1'b0, "still off before wake");
    wake_req = 1; tick(); wake_req = 0;
    chk("R5", core_pwr_en, 1'b1, "power on at wake");
    chk("R5", rst_req, 1'b1, "reset requested");
    tick(2);
    pwr_good = 1; tick();
    chk("R5", rst_req, 1'b0, "reset request drops on power good");
    tick(2);
    chk("R5", hold_n, 1'b0, "clamp held during reset");
    sw_ret_clr = 1; tick(); sw_ret_clr = 0;
    chk("R7", ret_flag, 1'b1, "clear ignored before unclamp");
    core_rst_n = 1; tick();
    chk("R5", hold_n, 1'b1, "clamp released after reset");
    sw_cke_set = 1; tick(); sw_cke_set = 0;
    chk("R8", cke_err, 1'b1, "refused set while flag set");
    chk("R8", cke_pad, 1'b0, "pad stays low while flag set");
    sw_ret_clr = 1; tick(); sw_ret_clr = 0;
    chk("R7", ret_flag, 1'b0, "flag cleared");
    sw_cke_set = 1; tick(); sw_cke_set = 0;
    chk("R1", cke_pad, 1'b1, "cke allowed after clear");
    // second backup: wake without any core reset
    bkp_req = 1; tick(); bkp_req = 0;
    tick();
    sr_ack = 1; tick(); sr_ack = 0;
    tick(D + 1);
    chk("R3", ret_flag, 1'b1, "second backup flag");
    sw_ret_clr = 1; tick(); sw_ret_clr = 0;
    chk("R7", ret_flag, 1'b1, "clear ignored during off");
    wake_req = 1; tick(); wake_req = 0;
    tick(4);
    chk("R5", hold_n, 1'b0, "clamp kept without reset seen");
    aon_rst_n = 0; tick();
    chk("R10", hold_n, 1'b1, "aon reset releases clamp");
    chk("R10", ret_flag, 1'b0, "aon reset clears flag");
    chk("R10", rst_req, 1'b0, "aon reset clears rst_req");
    aon_rst_n = 1; tick(2);
    summary();
  end
endmodule